// File: doc/BRIEF.md
# Two-Parameter Least-Squares Correction Unit

This unit finishes a linear least-squares track fit that has two free parameters. Upstream logic accumulates two weighted sums for each seed. The unit takes those two sums, the seed's hit-pattern class, its curvature bin and its coarse curvature guess. It returns an angle correction, a curvature correction and a refined curvature.

There is no matrix inversion at run time. For each hit pattern and curvature bin, a set of precomputed coefficients, including a shared reciprocal factor, turns the sums into corrections. The only run-time operations are multiplies, subtractions and fixed arithmetic shifts.

The coefficient tables are written through a simple write port. The datapath is a five-stage pipeline that accepts a seed on every clock.

Top module: `lsq_solve_unit`

## Requirements
- R1: During and straight after reset, `out_valid` is 0 and `out_dphi`, `out_drho` and `out_rho` are all 0.
- R2: A seed presented with `in_valid` high is sampled at a rising edge. Its results appear with `out_valid` high after the fifth rising edge, counting the sampling edge as the first. A new seed may be presented on every cycle, and `out_valid` is never high without a matching seed.
- R3: The angle correction is `out_dphi = (((A*K1)>>>13) - ((B*K2)>>>13)) * R >>> 16`, where A and B are the two sums. The result is kept as its low DPHI_W bits in two's complement.
- R4: The curvature correction is `((A*K2)>>>14 - (B*K3)>>>14) * R >>> 16`. `out_drho` is its low DRHO_W bits.
- R5: `out_rho` is the low RHO_W bits of `in_curv*4` plus the full-precision curvature correction.
- R6: K1, K2 and R are selected by the address `{class, bin}`, with class in the upper bits. K3 is selected by class alone, so the bin has no effect on K3.
- R7: A write with `tbl_we` high stores `tbl_data` at the next rising edge. `tbl_sel` picks the table: 0 for K1, 1 for K2, 2 for R, 3 for K3. The address is `tbl_addr = {class, bin}`, and a K3 write uses only the class field. A seed sampled at any edge after the write edge uses the new value.
- R8: While `out_valid` is low, all three result outputs keep their previous values.
- R9: Every shift is arithmetic on signed values, so negative intermediate values round toward minus infinity. This holds at the extreme input values as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Seed present this cycle |
| in_sum_a | input | SUM_W | First accumulated sum, signed |
| in_sum_b | input | SUM_W | Second accumulated sum, signed |
| in_class | input | CLASS_W | Hit-pattern class index |
| in_bin | input | BIN_W | Curvature bin index |
| in_curv | input | CURV_W | Coarse curvature guess, signed |
| tbl_we | input | 1 | Coefficient write enable |
| tbl_sel | input | 2 | Target table: 0 K1, 1 K2, 2 R, 3 K3 |
| tbl_addr | input | CLASS_W+BIN_W | Write address {class, bin} |
| tbl_data | input | COEF_W | Coefficient value, signed |
| out_valid | output | 1 | Results valid |
| out_dphi | output | DPHI_W | Angle correction, signed |
| out_drho | output | DRHO_W | Curvature correction, signed |
| out_rho | output | RHO_W | Refined curvature, signed |

## Verification
Each seed's three results are due together, on the fifth rising edge after the seed is sampled. No result of this block arrives at any other cycle.

A coefficient write takes effect for seeds sampled from the edge after the write. Every expected entry in the bench therefore records the cycle in which it is due, and the bench computes its values from the tables as they stood when the seed was driven.

On every falling edge the bench does one of two things. If the head entry is due in that cycle, it compares the outputs with that entry. Otherwise it requires `out_valid` low and all results unchanged.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    // Fixed-point scaling of the correction arithmetic
    localparam int SH_PHI   = 13;
    localparam int SH_RHO   = 14;
    localparam int SH_RECIP = 16;

    // Coefficient table select codes
    typedef enum logic [1:0] {
        TBL_K1    = 2'd0,
        TBL_K2    = 2'd1,
        TBL_RECIP = 2'd2,
        TBL_K3    = 2'd3
    } tbl_sel_e;

    localparam int N_FULL_TABLES = 3;

endpackage

// File: rtl/lsq_coef_store.sv
module lsq_coef_store
    import lsq_pkg::*;
#(
    parameter int CLASS_W = 4,
    parameter int BIN_W   = 3,
    parameter int COEF_W  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CLASS_W-1:0]          rd_class,
    input  logic [BIN_W-1:0]            rd_bin,
    input  logic                        we,
    input  logic [1:0]                  sel,
    input  logic [CLASS_W+BIN_W-1:0]    wr_addr,
    input  logic signed [COEF_W-1:0]    wr_data,
    output logic signed [COEF_W-1:0]    k1,
    output logic signed [COEF_W-1:0]    k2,
    output logic signed [COEF_W-1:0]    k3,
    output logic signed [COEF_W-1:0]    recip
);

    localparam int ADDR_W  = CLASS_W + BIN_W;
    localparam int N_FULL  = 1 << ADDR_W;
    localparam int N_CLASS = 1 << CLASS_W;

    typedef struct packed {
        logic [COEF_W-1:0] k1;
        logic [COEF_W-1:0] k2;
        logic [COEF_W-1:0] k3;
        logic [COEF_W-1:0] recip;
    } coef_t;

    logic [ADDR_W-1:0] rd_addr;
    logic [N_FULL_TABLES-1:0][COEF_W-1:0] full_rd;
    logic [COEF_W-1:0] k3_rd;
    coef_t rd_d, rd_q;

    assign rd_addr = {rd_class, rd_bin};

    // Tables indexed by class and bin (K1, K2, reciprocal)
    genvar gk;
    generate
        for (gk = 0; gk < N_FULL_TABLES; gk++) begin : g_full
            logic [COEF_W-1:0] mem [N_FULL];
            always_ff @(posedge clk) begin
                if (we && sel == 2'(gk)) begin
                    mem[wr_addr] <= wr_data;
                end
            end
            assign full_rd[gk] = mem[rd_addr];
        end
    endgenerate

    // Table indexed by class only (K3)
    logic [COEF_W-1:0] k3_mem [N_CLASS];
    always_ff @(posedge clk) begin
        if (we && sel == TBL_K3) begin
            k3_mem[wr_addr[ADDR_W-1:BIN_W]] <= wr_data;
        end
    end
    assign k3_rd = k3_mem[rd_class];

    always_comb begin
        rd_d       = rd_q;
        rd_d.k1    = full_rd[TBL_K1];
        rd_d.k2    = full_rd[TBL_K2];
        rd_d.recip = full_rd[TBL_RECIP];
        rd_d.k3    = k3_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign k1    = $signed(rd_q.k1);
    assign k2    = $signed(rd_q.k2);
    assign k3    = $signed(rd_q.k3);
    assign recip = $signed(rd_q.recip);

endmodule

// File: rtl/lsq_solve_core.sv
module lsq_solve_core
    import lsq_pkg::*;
#(
    parameter int SUM_W  = 20,
    parameter int COEF_W = 16,
    parameter int CURV_W = 6,
    parameter int DPHI_W = 18,
    parameter int DRHO_W = 18,
    parameter int RHO_W  = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic signed [SUM_W-1:0]   in_sum_a,
    input  logic signed [SUM_W-1:0]   in_sum_b,
    input  logic signed [CURV_W-1:0]  in_curv,
    input  logic signed [COEF_W-1:0]  k1,
    input  logic signed [COEF_W-1:0]  k2,
    input  logic signed [COEF_W-1:0]  k3,
    input  logic signed [COEF_W-1:0]  recip,
    output logic                      out_valid,
    output logic signed [DPHI_W-1:0]  out_dphi,
    output logic signed [DRHO_W-1:0]  out_drho,
    output logic signed [RHO_W-1:0]   out_rho
);

    localparam int P_W   = SUM_W + COEF_W;
    localparam int DF_W  = P_W + 1;
    localparam int Q_W   = DF_W + COEF_W;
    localparam int CMP_W = (RHO_W < DRHO_W) ? RHO_W : DRHO_W;

    typedef struct packed {
        // stage 1: operands aligned with table read
        logic              v1;
        logic [SUM_W-1:0]  a1;
        logic [SUM_W-1:0]  b1;
        logic [CURV_W-1:0] r1;
        // stage 2: four products
        logic              v2;
        logic [P_W-1:0]    pa1;
        logic [P_W-1:0]    pb2;
        logic [P_W-1:0]    pa2;
        logic [P_W-1:0]    pb3;
        logic [COEF_W-1:0] d2;
        logic [CURV_W-1:0] r2;
        // stage 3: scaled differences
        logic              v3;
        logic [DF_W-1:0]   dp3;
        logic [DF_W-1:0]   dr3;
        logic [COEF_W-1:0] d3;
        logic [CURV_W-1:0] r3;
        // stage 4: reciprocal products
        logic              v4;
        logic [Q_W-1:0]    qp4;
        logic [Q_W-1:0]    qr4;
        logic [CURV_W-1:0] r4;
        // stage 5: results
        logic              v5;
        logic [DPHI_W-1:0] phi5;
        logic [DRHO_W-1:0] drho5;
        logic [RHO_W-1:0]  rho5;
    } pipe_t;

    pipe_t p_d, p_q;
    logic [2:0] seen_d, seen_q;

    always_comb begin
        p_d = p_q;

        p_d.v1 = in_valid;
        p_d.a1 = in_sum_a;
        p_d.b1 = in_sum_b;
        p_d.r1 = in_curv;

        p_d.v2  = p_q.v1;
        p_d.pa1 = P_W'($signed(p_q.a1)) * P_W'(k1);
        p_d.pb2 = P_W'($signed(p_q.b1)) * P_W'(k2);
        p_d.pa2 = P_W'($signed(p_q.a1)) * P_W'(k2);
        p_d.pb3 = P_W'($signed(p_q.b1)) * P_W'(k3);
        p_d.d2  = recip;
        p_d.r2  = p_q.r1;

        p_d.v3  = p_q.v2;
        p_d.dp3 = DF_W'($signed(p_q.pa1) >>> SH_PHI) - DF_W'($signed(p_q.pb2) >>> SH_PHI);
        p_d.dr3 = DF_W'($signed(p_q.pa2) >>> SH_RHO) - DF_W'($signed(p_q.pb3) >>> SH_RHO);
        p_d.d3  = p_q.d2;
        p_d.r3  = p_q.r2;

        p_d.v4  = p_q.v3;
        p_d.qp4 = Q_W'($signed(p_q.dp3)) * Q_W'($signed(p_q.d3));
        p_d.qr4 = Q_W'($signed(p_q.dr3)) * Q_W'($signed(p_q.d3));
        p_d.r4  = p_q.r3;

        p_d.v5 = p_q.v4;
        if (p_q.v4) begin
            p_d.phi5  = DPHI_W'($signed(p_q.qp4) >>> SH_RECIP);
            p_d.drho5 = DRHO_W'($signed(p_q.qr4) >>> SH_RECIP);
            p_d.rho5  = RHO_W'((Q_W'($signed(p_q.r4)) <<< 2)
                               + ($signed(p_q.qr4) >>> SH_RECIP));
        end

        seen_d = (seen_q == 3'd7) ? seen_q : seen_q + 3'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q    <= '0;
            seen_q <= '0;
        end else begin
            p_q    <= p_d;
            seen_q <= seen_d;
        end
    end

    assign out_valid = p_q.v5;
    assign out_dphi  = $signed(p_q.phi5);
    assign out_drho  = $signed(p_q.drho5);
    assign out_rho   = $signed(p_q.rho5);

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 3'd5) |-> (out_valid == $past(in_valid, 5))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 3'd2 && !out_valid)
            |-> ($stable(out_dphi) && $stable(out_drho) && $stable(out_rho))); // R8

    AST_ZERO_SUMS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 3'd5 && $past(in_valid && in_sum_a == '0 && in_sum_b == '0, 5))
            |-> (out_valid && out_dphi == '0 && out_drho == '0)); // R3

    AST_RHO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 3'd5 && out_valid)
            |-> (CMP_W'(out_rho - (RHO_W'($signed($past(in_curv, 5))) <<< 2))
                 == CMP_W'(out_drho))); // R5

endmodule

// File: rtl/lsq_solve_unit.sv
module lsq_solve_unit
    import lsq_pkg::*;
#(
    parameter int SUM_W   = 20,
    parameter int COEF_W  = 16,
    parameter int CURV_W  = 6,
    parameter int CLASS_W = 4,
    parameter int BIN_W   = 3,
    parameter int DPHI_W  = 18,
    parameter int DRHO_W  = 18,
    parameter int RHO_W   = 18
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic signed [SUM_W-1:0]     in_sum_a,
    input  logic signed [SUM_W-1:0]     in_sum_b,
    input  logic [CLASS_W-1:0]          in_class,
    input  logic [BIN_W-1:0]            in_bin,
    input  logic signed [CURV_W-1:0]    in_curv,
    input  logic                        tbl_we,
    input  logic [1:0]                  tbl_sel,
    input  logic [CLASS_W+BIN_W-1:0]    tbl_addr,
    input  logic signed [COEF_W-1:0]    tbl_data,
    output logic                        out_valid,
    output logic signed [DPHI_W-1:0]    out_dphi,
    output logic signed [DRHO_W-1:0]    out_drho,
    output logic signed [RHO_W-1:0]     out_rho
);

    logic signed [COEF_W-1:0] k1, k2, k3, recip;

    lsq_coef_store #(
        .CLASS_W (CLASS_W),
        .BIN_W   (BIN_W),
        .COEF_W  (COEF_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_class (in_class),
        .rd_bin   (in_bin),
        .we       (tbl_we),
        .sel      (tbl_sel),
        .wr_addr  (tbl_addr),
        .wr_data  (tbl_data),
        .k1       (k1),
        .k2       (k2),
        .k3       (k3),
        .recip    (recip)
    );

    lsq_solve_core #(
        .SUM_W  (SUM_W),
        .COEF_W (COEF_W),
        .CURV_W (CURV_W),
        .DPHI_W (DPHI_W),
        .DRHO_W (DRHO_W),
        .RHO_W  (RHO_W)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sum_a  (in_sum_a),
        .in_sum_b  (in_sum_b),
        .in_curv   (in_curv),
        .k1        (k1),
        .k2        (k2),
        .k3        (k3),
        .recip     (recip),
        .out_valid (out_valid),
        .out_dphi  (out_dphi),
        .out_drho  (out_drho),
        .out_rho   (out_rho)
    );

endmodule

// File: tb/lsq_solve_unit_test.sv
module lsq_solve_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int SUM_W = 20, COEF_W = 16, CURV_W = 6;
    localparam int CLASS_W = 4, BIN_W = 3;
    localparam int DPHI_W = 18, DRHO_W = 18, RHO_W = 18;
    localparam int N_FULL = 1 << (CLASS_W + BIN_W);
    localparam int N_CLASS = 1 << CLASS_W;
    localparam int LATENCY = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [SUM_W-1:0] in_sum_a = '0, in_sum_b = '0;
    logic [CLASS_W-1:0] in_class = '0;
    logic [BIN_W-1:0] in_bin = '0;
    logic signed [CURV_W-1:0] in_curv = '0;
    logic tbl_we = 1'b0;
    logic [1:0] tbl_sel = '0;
    logic [CLASS_W+BIN_W-1:0] tbl_addr = '0;
    logic signed [COEF_W-1:0] tbl_data = '0;
    logic out_valid;
    logic signed [DPHI_W-1:0] out_dphi;
    logic signed [DRHO_W-1:0] out_drho;
    logic signed [RHO_W-1:0] out_rho;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsq_solve_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_sum_a(in_sum_a), .in_sum_b(in_sum_b),
        .in_class(in_class), .in_bin(in_bin), .in_curv(in_curv),
        .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .out_valid(out_valid), .out_dphi(out_dphi), .out_drho(out_drho), .out_rho(out_rho)
    );

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit run_chk = 1'b0;

    longint m_k1 [N_FULL];
    longint m_k2 [N_FULL];
    longint m_rc [N_FULL];
    longint m_k3 [N_CLASS];

    typedef struct {
        int     due;
        longint phi;
        longint drho;
        longint rho;
        string  tag;
    } exp_t;
    exp_t expq[$];

    longint last_phi = 0, last_drho = 0, last_rho = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint wrap(input longint v, input int w);
        longint m;
        m = v & ((64'sd1 <<< w) - 1);
        if (m[w-1]) m = m - (64'sd1 <<< w);
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Reference model and checker, compared every falling edge
    always @(negedge clk) begin
        if (run_chk) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
                exp_t e;
                e = expq.pop_front();
                check(out_valid == 1'b1, {"R2 valid ", e.tag}, longint'(out_valid), 1);
                check(longint'(out_dphi) == e.phi, {"R3 dphi ", e.tag}, longint'(out_dphi), e.phi);
                check(longint'(out_drho) == e.drho, {"R4 drho ", e.tag}, longint'(out_drho), e.drho);
                check(longint'(out_rho) == e.rho, {"R5 rho ", e.tag}, longint'(out_rho), e.rho);
            end else begin
                check(out_valid == 1'b0, "R2 spurious valid", longint'(out_valid), 0);
                check(longint'(out_dphi) == last_phi, "R8 dphi hold", longint'(out_dphi), last_phi);
                check(longint'(out_drho) == last_drho, "R8 drho hold", longint'(out_drho), last_drho);
                check(longint'(out_rho) == last_rho, "R8 rho hold", longint'(out_rho), last_rho);
            end
            last_phi  = longint'(out_dphi);
            last_drho = longint'(out_drho);
            last_rho  = longint'(out_rho);
        end
    end

    task automatic write_tbl(input int sel, input int addr, input longint val);
        @(negedge clk);
        in_valid = 1'b0;
        tbl_we   = 1'b1;
        tbl_sel  = 2'(sel);
        tbl_addr = (CLASS_W+BIN_W)'(addr);
        tbl_data = COEF_W'(val);
        case (sel)
            0: m_k1[addr] = wrap(val, COEF_W);
            1: m_k2[addr] = wrap(val, COEF_W);
            2: m_rc[addr] = wrap(val, COEF_W);
            default: m_k3[addr >> BIN_W] = wrap(val, COEF_W);
        endcase
    endtask

    task automatic seed(input longint a, input longint b, input int cls, input int bin,
                        input longint cv, input string tag);
        exp_t e;
        int idx;
        longint t1, t2, u1, u2, dphi_f, drho_f;
        @(negedge clk);
        tbl_we   = 1'b0;
        in_valid = 1'b1;
        in_sum_a = SUM_W'(a);
        in_sum_b = SUM_W'(b);
        in_class = CLASS_W'(cls);
        in_bin   = BIN_W'(bin);
        in_curv  = CURV_W'(cv);
        a  = wrap(a, SUM_W);
        b  = wrap(b, SUM_W);
        cv = wrap(cv, CURV_W);
        idx = (cls << BIN_W) | bin;
        t1 = (a * m_k1[idx]) >>> 13;
        t2 = (b * m_k2[idx]) >>> 13;
        u1 = (a * m_k2[idx]) >>> 14;
        u2 = (b * m_k3[cls]) >>> 14;
        dphi_f = ((t1 - t2) * m_rc[idx]) >>> 16;
        drho_f = ((u1 - u2) * m_rc[idx]) >>> 16;
        e.due  = cyc + LATENCY;
        e.phi  = wrap(dphi_f, DPHI_W);
        e.drho = wrap(drho_f, DRHO_W);
        e.rho  = wrap(cv * 4 + drho_f, RHO_W);
        e.tag  = tag;
        expq.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tbl_we   = 1'b0;
            in_valid = 1'b0;
        end
    endtask

    function automatic longint rnd(input int w);
        logic [31:0] r;
        r = $urandom;
        return wrap(longint'(r), w);
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", longint'(out_valid), 0);
        check(out_dphi == '0 && out_drho == '0 && out_rho == '0, "R1 outputs in reset",
              longint'(out_rho), 0);
        rst_n   = 1'b1;
        run_chk = 1'b1;

        // R7: load all tables through the write port
        for (int i = 0; i < N_FULL; i++) begin
            write_tbl(0, i, wrap(longint'(i) * 7919 + 1234, COEF_W));
            write_tbl(1, i, wrap(longint'(i) * 4513 - 9000, COEF_W));
            write_tbl(2, i, (longint'(i) * 911 + 300) % 32768);
        end
        for (int j = 0; j < N_CLASS; j++)
            write_tbl(3, j << BIN_W, wrap(longint'(j) * 6007 + 55, COEF_W));
        idle(2);

        // R5: zero sums give zero corrections, rho is the scaled guess
        seed(0, 0, 3, 2, -17, "R5 zero sums");
        seed(0, 0, 9, 0, 31, "R5 zero sums max curv");
        idle(8);

        // R2, R3, R4: back-to-back seeds
        for (int i = 0; i < 40; i++)
            seed(rnd(SUM_W), rnd(SUM_W), i % N_CLASS, (i * 3) % (1 << BIN_W),
                 rnd(CURV_W), "R2 back-to-back");
        idle(8);

        // R9: extremes and small negative values
        seed(-524288, 524287, 15, 7, -32, "R9 extreme neg a");
        seed(524287, -524288, 15, 7, 31, "R9 extreme pos a");
        seed(-1, 1, 4, 4, -1, "R9 minus one");
        seed(-3, -5, 0, 0, 0, "R9 small negatives");
        idle(8);

        // R6: same class across all bins, K3 shared by class
        for (int bn = 0; bn < (1 << BIN_W); bn++)
            seed(0, -123457, 6, bn, 5, "R6 class shared K3");
        idle(8);

        // R7: rewrite entries, next seed uses the new values
        write_tbl(3, (5 << BIN_W) | 2, -30000);
        write_tbl(0, (5 << BIN_W) | 1, 32767);
        write_tbl(2, (5 << BIN_W) | 1, 32767);
        seed(250000, -250000, 5, 1, 12, "R7 rewritten tables");
        seed(-77777, 88888, 5, 6, -12, "R7 K3 from class only");
        idle(8);

        // R8: sparse seeds with idle gaps, outputs must hold between
        for (int i = 0; i < 6; i++) begin
            seed(rnd(SUM_W), rnd(SUM_W), (i * 5) % N_CLASS, i % (1 << BIN_W),
                 rnd(CURV_W), "R8 gapped");
            idle(3 + i);
        end
        idle(10);

        check(expq.size() == 0, "R2 all results delivered", longint'(expq.size()), 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule